// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial frames of eleven bit times. Each frame has one low start bit, eight data bits sent least significant bit first, a ninth bit and one stop bit. The line is sampled on a sixteen-times-oversampled tick, and every bit is decided by a vote over three samples taken around its centre. The block is meant to sit in a multi-drop network. A controller marks address frames by sending a 1 in the ninth bit. Each listening node holds its own address and a care mask, and it only wakes when a frame is addressed to it or to a broadcast address.

The receiver hands over one byte and the ninth bit at a time. It raises a received flag, which the consumer clears. While the flag is still set, the holding register belongs to the consumer, and later frames are dropped. A separate framing-error flag reports the stop bit of the most recently completed frame.

The control machine has five states. RX_HUNT watches for a falling edge. RX_START confirms the start bit. RX_DATA shifts in eight bits. RX_NINTH captures the ninth bit. RX_STOP judges the stop bit and delivers the frame. The transitions are:
- hunt to start: a falling edge is seen while enabled.
- start to hunt: the start vote is high (a false start).
- start to data: the sixteenth tick of the start bit.
- data to ninth: the sixteenth tick of the eighth data bit.
- ninth to stop: the sixteenth tick of the ninth bit.
- stop to hunt: the stop vote at mid-bit.
- any state to hunt: the enable input is low.

Top module: `ninebit_addr_rx`

## Requirements
- R1: After reset, `rx_flag`, `frame_err`, `rx_bit9` are 0 and `rx_data` is 8'h00.
- R2: A frame starts only on a tick where the synchronized line reads 0 after reading 1 on the previous tick, and only while `rx_en` is 1. With `rx_en` at 0 the receiver returns to and stays in hunting, and no output changes.
- R3: If the start-bit vote at mid-bit is 1, the frame is abandoned, nothing is delivered, and hunting for a falling edge resumes at once.
- R4: Each bit is decided by a 2-of-3 majority of the samples on tick phases 7, 8 and 9, where phase 0 is the tick that saw the falling edge. Data bits arrive least significant bit first.
- R5: `rx_flag` rises on the cycle after phase 9 of the stop bit. `rx_data` and `rx_bit9` are loaded at the same time, whatever the stop bit's value.
- R6: A frame that completes while `rx_flag` is 1 is discarded, and `rx_data` and `rx_bit9` keep their values.
- R7: A 1 on `flag_clr` clears `rx_flag` on the next cycle.
- R8: With `mp_mode` at 1, a frame is delivered only if its ninth bit is 1 and ((byte XOR `own_addr`) AND `care_mask`) is zero. Bits with a 0 in the mask are don't-care.
- R9: With `mp_mode` at 1, a frame whose ninth bit is 1 is also delivered when byte AND B equals B, where B = `own_addr` OR `care_mask`. Zero bits of B are don't-care.
- R10: `frame_err` is updated at the stop-bit decision of every completed frame: it goes to 1 when the stop vote is 0 and to 0 when it is 1. This holds whether the frame was delivered, filtered or discarded.
- R11: A frame rejected by the address filter leaves `rx_flag`, `rx_data` and `rx_bit9` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | Address-filtering mode |
| own_addr | input | 8 | Node address |
| care_mask | input | 8 | Address care mask (1 = compare) |
| flag_clr | input | 1 | Clears the received flag |
| rx_data | output | 8 | Last delivered byte |
| rx_bit9 | output | 1 | Ninth bit of the last delivered frame |
| rx_flag | output | 1 | Frame delivered and not yet cleared |
| frame_err | output | 1 | Stop bit of the last completed frame was low |

## Verification
On every cycle, the bound checker enforces the following:
- The enable forces hunting.
- A flag clear takes effect.
- The holding register stays frozen while the flag is up.
- Loads happen only together with a rising flag, and only out of the stop state.
- In address mode, a rising flag always carries a ninth bit of 1 and a byte that hits the own or broadcast pattern.

Other behaviours only show up in the bench's scenarios:
- the three-sample vote against single and double corrupted samples;
- least-significant-first bit order;
- false-start rejection and recovery;
- the framing-error value for each frame;
- rejected address frames leaving the outputs untouched.

// File: rtl/ninebit_rx_pkg.sv
`timescale 1ns/1ps
package ninebit_rx_pkg;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/ninebit_rx_sync.sv
`timescale 1ns/1ps
module ninebit_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= RESET_VAL;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ninebit_rx_voter.sv
`timescale 1ns/1ps
module ninebit_rx_voter
    import ninebit_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line,
    input  logic [CNT_W-1:0] phase,
    output logic             bit_val,
    output logic             vote_now
);

    localparam int MID_PH   = OVS / 2;
    localparam int EARLY_PH = MID_PH - 1;
    localparam int LATE_PH  = MID_PH + 1;

    logic early_q;
    logic mid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_q <= 1'b1;
            mid_q   <= 1'b1;
        end else if (tick) begin
            if (phase == CNT_W'(EARLY_PH)) early_q <= line;
            if (phase == CNT_W'(MID_PH))   mid_q   <= line;
        end
    end

    assign vote_now = tick && (phase == CNT_W'(LATE_PH));
    assign bit_val  = vote3(early_q, mid_q, line);

endmodule

// File: rtl/ninebit_rx_addr_match.sv
`timescale 1ns/1ps
module ninebit_rx_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] byte_in,
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] care_mask,
    output logic         hit
);

    logic [W-1:0] bcast_pat;
    logic         own_hit;
    logic         bcast_hit;

    always_comb begin
        bcast_pat = own_addr | care_mask;
        own_hit   = ((byte_in ^ own_addr) & care_mask) == '0;
        bcast_hit = (byte_in & bcast_pat) == bcast_pat;
        hit       = own_hit | bcast_hit;
    end

endmodule

// File: rtl/ninebit_addr_rx.sv
`timescale 1ns/1ps
module ninebit_addr_rx
    import ninebit_rx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          tick16,
    input  logic          rx_en,
    input  logic          mp_mode,
    input  logic [DW-1:0] own_addr,
    input  logic [DW-1:0] care_mask,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_flag,
    output logic          frame_err
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

    rx_state_t         state_q, state_d;
    logic              line_s;
    logic              line_prev;
    logic [CNT_W-1:0]  phase_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DW-1:0]     shift_q;
    logic              ninth_q;
    logic              bit_val;
    logic              vote_now;
    logic              fall_seen;
    logic              last_phase;
    logic              addr_hit;
    logic              stop_done;
    logic              accept;

    ninebit_rx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ser_in),
        .q     (line_s)
    );

    ninebit_rx_voter #(
        .OVS   (OVS),
        .CNT_W (CNT_W)
    ) voter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .line     (line_s),
        .phase    (phase_q),
        .bit_val  (bit_val),
        .vote_now (vote_now)
    );

    ninebit_rx_addr_match #(
        .W (DW)
    ) match_i (
        .byte_in   (shift_q),
        .own_addr  (own_addr),
        .care_mask (care_mask),
        .hit       (addr_hit)
    );

    assign fall_seen  = tick16 && rx_en && line_prev && !line_s;
    assign last_phase = tick16 && (phase_q == CNT_W'(OVS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: begin
                if (fall_seen) state_d = RX_START;
            end
            RX_START: begin
                if (vote_now && bit_val)  state_d = RX_HUNT;
                else if (last_phase)      state_d = RX_DATA;
            end
            RX_DATA: begin
                if (last_phase && (idx_q == IDX_W'(DW - 1))) state_d = RX_NINTH;
            end
            RX_NINTH: begin
                if (last_phase) state_d = RX_STOP;
            end
            RX_STOP: begin
                if (vote_now) state_d = RX_HUNT;
            end
            default: state_d = RX_HUNT;
        endcase
        if (!rx_en) state_d = RX_HUNT;
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RX_HUNT;
            phase_q   <= '0;
            idx_q     <= '0;
            line_prev <= 1'b1;
            shift_q   <= '0;
            ninth_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tick16) line_prev <= line_s;

            if (state_q == RX_HUNT || state_d == RX_HUNT) begin
                phase_q <= (state_d == RX_START) ? CNT_W'(1) : '0;
            end else if (tick16) begin
                phase_q <= (phase_q == CNT_W'(OVS - 1)) ? '0 : phase_q + CNT_W'(1);
            end

            if (state_q != RX_DATA)  idx_q <= '0;
            else if (last_phase)     idx_q <= idx_q + IDX_W'(1);

            if (state_q == RX_DATA && vote_now)
                shift_q <= {bit_val, shift_q[DW-1:1]};

            if (state_q == RX_NINTH && vote_now)
                ninth_q <= bit_val;
        end
    end

    assign stop_done = (state_q == RX_STOP) && vote_now && rx_en;
    assign accept    = !mp_mode || (ninth_q && addr_hit);

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_flag   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (stop_done) frame_err <= !bit_val;
            if (stop_done && !rx_flag && accept) begin
                rx_data <= shift_q;
                rx_bit9 <= ninth_q;
                rx_flag <= 1'b1;
            end else if (flag_clr) begin
                rx_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ninebit_addr_rx_chk.sv
`timescale 1ns/1ps
module ninebit_addr_rx_chk
    import ninebit_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          mp_mode,
    input logic          flag_clr,
    input logic [DW-1:0] own_addr,
    input logic [DW-1:0] care_mask,
    input logic [DW-1:0] rx_data,
    input logic          rx_bit9,
    input logic          rx_flag,
    input logic          frame_err,
    input rx_state_t     state_q
);

    AST_HUNT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state_q == RX_HUNT); // R2

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && flag_clr) |=> !rx_flag); // R7

    AST_HELD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |=> ($stable(rx_data) && $stable(rx_bit9))); // R6

    AST_LOAD_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_data) || !$stable(rx_bit9)) |-> $rose(rx_flag)); // R5

    AST_FLAG_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(state_q) == RX_STOP); // R5

    AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_mode && !rx_flag) |=> (!rx_flag || (rx_bit9 &&
            ((((rx_data ^ $past(own_addr)) & $past(care_mask)) == '0) ||
             ((rx_data & ($past(own_addr) | $past(care_mask))) ==
              ($past(own_addr) | $past(care_mask))))))); // R8 R9

    AST_ERR_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_err) |-> $past(state_q) == RX_STOP); // R10

endmodule

bind ninebit_addr_rx ninebit_addr_rx_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .mp_mode   (mp_mode),
    .flag_clr  (flag_clr),
    .own_addr  (own_addr),
    .care_mask (care_mask),
    .rx_data   (rx_data),
    .rx_bit9   (rx_bit9),
    .rx_flag   (rx_flag),
    .frame_err (frame_err),
    .state_q   (state_q)
);

// File: tb/ninebit_addr_rx_tb_top.sv
`timescale 1ns/1ps
module ninebit_addr_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_en = 1'b0;
    logic       mp_mode = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic [7:0] care_mask = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_flag;
    logic       frame_err;

    int n_checks = 0;
    int n_err = 0;

    logic       exp_flag = 1'b0;
    logic       exp_b9 = 1'b0;
    logic       exp_ferr = 1'b0;
    logic [7:0] exp_data = 8'h00;

    always #2.5 clk = ~clk;

    ninebit_addr_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .tick16    (tick16),
        .rx_en     (rx_en),
        .mp_mode   (mp_mode),
        .own_addr  (own_addr),
        .care_mask (care_mask),
        .flag_clr  (flag_clr),
        .rx_data   (rx_data),
        .rx_bit9   (rx_bit9),
        .rx_flag   (rx_flag),
        .frame_err (frame_err)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic check(input string req);
        n_checks++;
        if (rx_flag !== exp_flag || rx_data !== exp_data ||
            rx_bit9 !== exp_b9 || frame_err !== exp_ferr) begin
            n_err++;
            $display("FAIL %s: got flag=%b data=%h b9=%b ferr=%b, expected flag=%b data=%h b9=%b ferr=%b",
                     req, rx_flag, rx_data, rx_bit9, frame_err,
                     exp_flag, exp_data, exp_b9, exp_ferr);
        end
    endtask

    function automatic logic filter_pass(input logic [7:0] d, input logic b9);
        logic [7:0] bc;
        if (!mp_mode) return 1'b1;
        bc = own_addr | care_mask;
        return b9 && ((((d ^ own_addr) & care_mask) == 8'h00) || ((d & bc) == bc));
    endfunction

    task automatic model_frame(input logic [7:0] d, input logic b9, input logic stp);
        if (!rx_en) return;
        exp_ferr = !stp;
        if (!exp_flag && filter_pass(d, b9)) begin
            exp_flag = 1'b1;
            exp_data = d;
            exp_b9   = b9;
        end
    endtask

    task automatic one_tick(input logic v);
        @(negedge clk) ser_in = v;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk) tick16 = 1'b1;
        @(negedge clk) tick16 = 1'b0;
    endtask

    task automatic send_bit(input logic v, input logic [15:0] inv);
        for (int p = 0; p < 16; p++) one_tick(v ^ inv[p]);
    endtask

    // sends a frame; the phases in inv are corrupted in data bit sel
    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp,
                              input int sel, input logic [15:0] inv);
        one_tick(1'b1);
        one_tick(1'b1);
        send_bit(1'b0, 16'h0000);
        for (int i = 0; i < 8; i++) send_bit(d[i], (i == sel) ? inv : 16'h0000);
        send_bit(b9, 16'h0000);
        send_bit(stp, 16'h0000);
        one_tick(1'b1);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        exp_flag = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: run did not complete, expected completion before timeout");
        report();
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = 32'h1d2c3b4a;
        void'($urandom(seed_v));

        repeat (5) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        rx_en = 1'b1;

        // plain delivery, stop high
        send_frame(8'h5A, 1'b1, 1'b1, 15, 16'h0);
        model_frame(8'h5A, 1'b1, 1'b1);
        check("R5 basic delivery");

        // overrun: second frame discarded, framing error still updated
        send_frame(8'hC3, 1'b0, 1'b0, 15, 16'h0);
        model_frame(8'hC3, 1'b0, 1'b0);
        check("R6 R10 discard while full");

        clear_flag();
        check("R7 flag clear");

        // single corrupted sample in the vote window and two outside it
        send_frame(8'h96, 1'b0, 1'b1, 2, 16'h1108);
        model_frame(8'h96, 1'b0, 1'b1);
        check("R4 single bad sample outvoted");
        clear_flag();

        // two corrupted samples flip the bit (bit 5, LSB first)
        send_frame(8'h81, 1'b1, 1'b1, 5, 16'h0180);
        model_frame(8'h81 ^ 8'h20, 1'b1, 1'b1);
        check("R4 majority flips bit 5");
        clear_flag();

        // false start: low for six ticks only
        one_tick(1'b1);
        one_tick(1'b1);
        for (int k = 0; k < 6; k++) one_tick(1'b0);
        for (int k = 0; k < 24; k++) one_tick(1'b1);
        check("R3 false start ignored");
        send_frame(8'h3C, 1'b0, 1'b1, 15, 16'h0);
        model_frame(8'h3C, 1'b0, 1'b1);
        check("R3 recovery after false start");
        clear_flag();

        // receiver disabled
        rx_en = 1'b0;
        send_frame(8'h77, 1'b1, 1'b0, 15, 16'h0);
        model_frame(8'h77, 1'b1, 1'b0);
        check("R2 disabled receiver ignores frame");
        rx_en = 1'b1;

        // stop value does not gate delivery
        send_frame(8'hE4, 1'b1, 1'b0, 15, 16'h0);
        model_frame(8'hE4, 1'b1, 1'b0);
        check("R5 R10 delivered with low stop");
        clear_flag();
        send_frame(8'h12, 1'b0, 1'b1, 15, 16'h0);
        model_frame(8'h12, 1'b0, 1'b1);
        check("R10 framing error cleared by good stop");
        clear_flag();

        // address filtering: own 1010_0110, mask 1111_0011, broadcast 1111_0111
        mp_mode   = 1'b1;
        own_addr  = 8'hA6;
        care_mask = 8'hF3;
        send_frame(8'hAE, 1'b1, 1'b1, 15, 16'h0);
        model_frame(8'hAE, 1'b1, 1'b1);
        check("R8 own address with don't-care bits");
        clear_flag();
        send_frame(8'hA6, 1'b0, 1'b1, 15, 16'h0);
        model_frame(8'hA6, 1'b0, 1'b1);
        check("R11 data frame filtered");
        send_frame(8'h56, 1'b1, 1'b0, 15, 16'h0);
        model_frame(8'h56, 1'b1, 1'b0);
        check("R8 R11 R10 mismatched address filtered");
        send_frame(8'hF7, 1'b1, 1'b1, 15, 16'h0);
        model_frame(8'hF7, 1'b1, 1'b1);
        check("R9 broadcast address accepted");
        clear_flag();

        // constrained random frames
        for (int n = 0; n < 45; n++) begin
            logic [7:0] d;
            logic b9;
            logic stp;
            mp_mode   = $urandom_range(0, 1);
            own_addr  = 8'($urandom);
            care_mask = 8'($urandom);
            d = 8'($urandom);
            if ($urandom_range(0, 2) == 0) d = (own_addr & care_mask) | (8'($urandom) & ~care_mask);
            b9  = $urandom_range(0, 1);
            stp = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 9) < 7) clear_flag();
            send_frame(d, b9, stp, 15, 16'h0);
            model_frame(d, b9, stp);
            check(mp_mode ? "R8 R9 R11 random address frame" : "R5 R6 R10 random frame");
        end

        report();
        $finish;
    end

endmodule